// File: doc/BRIEF.md
# Edge-Counting Capture Timer with Buffered Capture

This block is a 16-bit timer channel whose counter is advanced by edges of an external count pin rather than by the system clock. A second pin, the capture pin, takes a snapshot of the counter into capture register A on a chosen edge. Optionally, each snapshot first moves the previous contents of A into buffer register C. The counter can also be cleared by the capture event. With both options on, one snapshot holds the latest period of a periodic signal and the other holds the period before it.

Two sticky flags report a capture and a counter wrap. They stay set until software clears them by writing zeros. Software reaches the block through a simple write port and a combinational read port. A run control bit drives a two-state sequencer. In ST_HALT the counter and the capture logic are frozen. In ST_COUNT edges are acted on. The transition GO (ST_HALT to ST_COUNT) is taken on the clock after the start bit is seen set. The transition STOP (ST_COUNT to ST_HALT) is taken on the clock after it is seen clear.

Both pins pass through a two-flop synchroniser and a one-flop edge detector. A pin change that is sampled at clock edge k therefore takes effect at clock edge k+2.

Top module: `cap_timer`

## Requirements
- R1: While running, the counter increases by one for each selected edge of `cnt_pin`. The count edge is chosen by control bits [4:3]: 0 selects rising, 1 selects falling, 2 or 3 selects both edges.
- R2: While the start bit (control bit 0) is 0, count and capture pin edges change neither the counter, register A, register C nor the flags.
- R3: While running, each selected edge of `cap_pin` loads the current counter value into register A and sets the capture flag (status bit 0). The capture edge is chosen by control bits [6:5] with the same encoding as R1.
- R4: With clear-on-capture (control bit 1) set, a capture sets the counter to 0. With it clear, counting continues from the current value.
- R5: With buffer mode (control bit 2) set, a capture moves the old value of register A into register C in the same cycle that A is loaded.
- R6: With buffer mode clear, captures leave register C unchanged.
- R7: A count edge while the counter is FFFFH makes the counter 0000H and sets the overflow flag (status bit 1).
- R8: A clearing capture together with a count edge while the counter is FFFFH sets both flags in the same cycle. It leaves A at FFFFH and the counter at 0000H.
- R9: Flags are sticky. Writing a 0 to a status bit clears that flag, and writing a 1 has no effect. A flag-setting event in the same cycle as a write of 0 leaves the flag set.
- R10: The register map is: address 0 control, address 1 status, address 2 counter, address 3 register A, address 4 register C. Reads of any other address return 0.
- R11: A write to address 2 loads the counter. This load takes priority over counting and clearing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| cnt_pin | input | 1 | External count clock |
| cap_pin | input | 1 | External capture input |

## Verification
The bench sweeps every combination of count edge, capture edge, clear-on-capture and buffer mode. It replays a fixed pin pattern for each combination against an arithmetic model. A design that decoded an edge code wrongly would show a count off by a factor of two or a capture taken at the wrong moment. A design that shifted the buffer unconditionally would corrupt C while buffer mode is off.

The bench raises both pins together with the counter preset to FFFFH. It polls the status register every cycle, so a design that sets the two flags in different cycles, or that lets the clear suppress the overflow, is caught. The bench also lands a write of 0 on the exact cycle of a capture. It halts the channel and toggles both pins. It writes ones to the status register. Any of these can expose a design whose flag or run priorities are reversed.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE     = 2'd0,
        EDGE_FALL     = 2'd1,
        EDGE_BOTH     = 2'd2,
        EDGE_BOTH_ALT = 2'd3
    } edge_sel_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CAPA = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_BUFC = 3'd4;

    localparam int CTRL_W      = 7;
    localparam int CB_START    = 0;
    localparam int CB_CLR      = 1;
    localparam int CB_BUF      = 2;
    localparam int CB_CNT_EDGE = 3;
    localparam int CB_CAP_EDGE = 5;

    localparam int SB_CAP = 0;
    localparam int SB_OVF = 1;

endpackage

// File: rtl/cap_timer_edge.sv
module cap_timer_edge
    import cap_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  edge_sel_e sel_i,
    output logic      pulse_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   now_s;
    logic                   rise_s;
    logic                   fall_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign now_s  = sync_q[SYNC_STAGES-1];
    assign rise_s = now_s & ~prev_q;
    assign fall_s = ~now_s & prev_q;

    always_comb begin
        unique case (sel_i)
            EDGE_RISE: pulse_o = rise_s;
            EDGE_FALL: pulse_o = fall_s;
            default:   pulse_o = rise_s | fall_s;
        endcase
    end

endmodule

// File: rtl/cap_timer_core.sv
module cap_timer_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         cnt_ev_i,
    input  logic         cap_ev_i,
    input  logic         clr_mode_i,
    input  logic         buf_en_i,
    input  logic         cnt_wr_i,
    input  logic         stat_wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] reg_a_o,
    output logic [W-1:0] reg_c_o,
    output logic         cap_flag_o,
    output logic         ovf_flag_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic do_cap;
    logic do_cnt;
    logic wrap;
    logic clr_cap_req;
    logic clr_ovf_req;

    assign do_cap      = run_i & cap_ev_i;
    assign do_cnt      = run_i & cnt_ev_i;
    assign wrap        = do_cnt & (count_o == CNT_MAX) & ~cnt_wr_i;
    assign clr_cap_req = stat_wr_i & ~wr_data_i[0];
    assign clr_ovf_req = stat_wr_i & ~wr_data_i[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (cnt_wr_i) begin
            count_o <= wr_data_i;
        end else if (do_cap && clr_mode_i) begin
            count_o <= '0;
        end else if (do_cnt) begin
            count_o <= count_o + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a_o <= '0;
            reg_c_o <= '0;
        end else if (do_cap) begin
            reg_a_o <= count_o;
            if (buf_en_i) begin
                reg_c_o <= reg_a_o;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_flag_o <= 1'b0;
            ovf_flag_o <= 1'b0;
        end else begin
            cap_flag_o <= do_cap | (cap_flag_o & ~clr_cap_req);
            ovf_flag_o <= wrap   | (ovf_flag_o & ~clr_ovf_req);
        end
    end

    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && !cnt_wr_i |=> $stable(count_o) && $stable(reg_a_o)); // R2
    AST_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && cap_ev_i |=> cap_flag_o); // R3
    AST_CLEAR_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && cap_ev_i && clr_mode_i && !cnt_wr_i |=> count_o == '0); // R4
    AST_BUFFER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && cap_ev_i && buf_en_i |=> reg_c_o == $past(reg_a_o)); // R5
    AST_BUFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en_i |=> $stable(reg_c_o)); // R6
    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && cnt_ev_i && count_o == CNT_MAX && !cnt_wr_i |=> ovf_flag_o && count_o == '0); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_flag_o && !(stat_wr_i && !wr_data_i[0]) |=> cap_flag_o); // R9
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> count_o == $past(wr_data_i)); // R11

endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              cnt_pin,
    input  logic              cap_pin
);

    localparam int NUM_PINS = 2;

    logic [CTRL_W-1:0]   ctrl_q;
    run_state_e          state_q;
    run_state_e          state_d;
    logic                run;
    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] pulses;
    edge_sel_e           sels [NUM_PINS];
    logic                cnt_wr;
    logic                stat_wr;
    logic [W-1:0]        count;
    logic [W-1:0]        reg_a;
    logic [W-1:0]        reg_c;
    logic                cap_flag;
    logic                ovf_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == ADR_CTRL) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    // Sequencer: GO (ST_HALT -> ST_COUNT) and STOP (ST_COUNT -> ST_HALT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctrl_q[CB_START])  state_d = ST_COUNT;
            ST_COUNT: if (!ctrl_q[CB_START]) state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HALT:  run = 1'b0;
            ST_COUNT: run = 1'b1;
        endcase
    end

    assign pins    = {cap_pin, cnt_pin};
    assign sels[0] = edge_sel_e'(ctrl_q[CB_CNT_EDGE +: 2]);
    assign sels[1] = edge_sel_e'(ctrl_q[CB_CAP_EDGE +: 2]);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        cap_timer_edge #(
            .SYNC_STAGES(SYNC_STAGES)
        ) i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[g]),
            .sel_i  (sels[g]),
            .pulse_o(pulses[g])
        );
    end

    assign cnt_wr  = wr_en && (wr_addr == ADR_CNT);
    assign stat_wr = wr_en && (wr_addr == ADR_STAT);

    cap_timer_core #(
        .W(W)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .cnt_ev_i  (pulses[0]),
        .cap_ev_i  (pulses[1]),
        .clr_mode_i(ctrl_q[CB_CLR]),
        .buf_en_i  (ctrl_q[CB_BUF]),
        .cnt_wr_i  (cnt_wr),
        .stat_wr_i (stat_wr),
        .wr_data_i (wr_data),
        .count_o   (count),
        .reg_a_o   (reg_a),
        .reg_c_o   (reg_c),
        .cap_flag_o(cap_flag),
        .ovf_flag_o(ovf_flag)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
            ADR_STAT: begin
                rd_data[SB_CAP] = cap_flag;
                rd_data[SB_OVF] = ovf_flag;
            end
            ADR_CNT:  rd_data = count;
            ADR_CAPA: rd_data = reg_a;
            ADR_BUFC: rd_data = reg_c;
            default:  rd_data = '0;
        endcase
    end

    AST_RUN_TRACKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[CB_START]) |=> run); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr > ADR_BUFC |-> rd_data == '0); // R10

endmodule

// File: tb/test_cap_timer.sv
`timescale 1ns/1ps
module test_cap_timer;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         cnt_pin = 1'b0;
    logic         cap_pin = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    int e_cnt, e_a, e_c;
    bit e_cf, e_of;
    int kmode, cmode;
    bit clr_m, buf_m, running;

    always #2 clk = ~clk;

    cap_timer i_cap_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_pin(cnt_pin), .cap_pin(cap_pin)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        @(negedge clk);
        rd_addr = a;
        #0.5 v = rd_data;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic bit picks(input int mode, input bit rising);
        if (mode == 0) return rising;
        if (mode == 1) return !rising;
        return 1'b1;
    endfunction

    function automatic void m_count();
        if (e_cnt == 65535) begin e_cnt = 0; e_of = 1'b1; end
        else e_cnt++;
    endfunction

    function automatic void m_cap();
        if (buf_m) e_c = e_a;
        e_a = e_cnt;
        e_cf = 1'b1;
        if (clr_m) e_cnt = 0;
    endfunction

    task automatic drive_cnt(input bit v);
        @(negedge clk) cnt_pin = v;
        if (running && picks(kmode, v)) m_count();
        settle();
    endtask

    task automatic drive_cap(input bit v);
        @(negedge clk) cap_pin = v;
        if (running && picks(cmode, v)) m_cap();
        settle();
    endtask

    task automatic set_ctrl(input bit st);
        running = st;
        wr(3'd0, W'({cmode[1:0], kmode[1:0], buf_m, clr_m, st}));
        settle();
    endtask

    task automatic check_all(input string tag);
        logic [W-1:0] v;
        rd(3'd2, v); chk({tag, " R1 counter"}, v, W'(e_cnt));
        rd(3'd3, v); chk({tag, " R3 capture A"}, v, W'(e_a));
        rd(3'd4, v); chk({tag, " R5 buffer C"}, v, W'(e_c));
        rd(3'd1, v); chk({tag, " R9 flags"}, v, W'({e_of, e_cf}));
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] v;
        logic [W-1:0] first_stat;
        e_cnt = 0; e_a = 0; e_c = 0; e_cf = 0; e_of = 0;
        kmode = 0; cmode = 0; clr_m = 0; buf_m = 0; running = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check_all("reset");
        rd(3'd0, v); chk("reset R10 control", v, '0);

        // Sweep every edge-mode and option combination (R1 R3 R4 R5 R6)
        for (int km = 0; km < 3; km++) begin
            for (int cm = 0; cm < 3; cm++) begin
                for (int opt = 0; opt < 4; opt++) begin
                    kmode = km; cmode = cm; clr_m = opt[0]; buf_m = opt[1];
                    set_ctrl(1'b0);
                    e_cnt = 16'h0100 * (km * 12 + cm * 4 + opt) + 3;
                    wr(3'd2, W'(e_cnt));          // R11 preset
                    wr(3'd1, '0);
                    e_cf = 0; e_of = 0;
                    set_ctrl(1'b1);
                    for (int p = 0; p < 3; p++) begin drive_cnt(1); drive_cnt(0); end
                    drive_cap(1); drive_cap(0);
                    check_all($sformatf("sweep k%0d c%0d o%0d a", km, cm, opt));
                    for (int p = 0; p < 2; p++) begin drive_cnt(1); drive_cnt(0); end
                    drive_cap(1); drive_cap(0);
                    check_all($sformatf("sweep k%0d c%0d o%0d b", km, cm, opt));
                end
            end
        end

        // R2: halted channel ignores both pins
        kmode = 2; cmode = 2; clr_m = 1; buf_m = 1;
        set_ctrl(1'b0);
        wr(3'd1, '0); e_cf = 0; e_of = 0;
        drive_cnt(1); drive_cnt(0); drive_cap(1); drive_cap(0);
        check_all("halted R2");

        // R7: wrap from FFFFH
        kmode = 0; cmode = 0; clr_m = 0; buf_m = 0;
        set_ctrl(1'b1);
        wr(3'd2, 16'hFFFE); e_cnt = 16'hFFFE;
        drive_cnt(1); drive_cnt(0);
        check_all("before wrap R7");
        drive_cnt(1); drive_cnt(0);
        check_all("wrap R7");

        // R8: clearing capture coincides with wrap
        clr_m = 1;
        set_ctrl(1'b1);
        wr(3'd2, 16'hFFFF); e_cnt = 16'hFFFF;
        wr(3'd1, '0); e_cf = 0; e_of = 0;
        @(negedge clk);
        rd_addr = 3'd1;
        cnt_pin = 1'b1; cap_pin = 1'b1;
        first_stat = '0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            #0.5;
            if (first_stat == '0) first_stat = rd_data;
        end
        chk("simultaneous R8 first status", first_stat, 16'h0003);
        e_a = 16'hFFFF; e_cnt = 0; e_cf = 1; e_of = 1;
        drive_cnt(0); drive_cap(0);
        check_all("simultaneous R8");

        // R9: writing ones changes nothing
        wr(3'd1, 16'h0003);
        rd(3'd1, v); chk("write ones R9", v, 16'h0003);
        wr(3'd1, 16'h0002); e_cf = 0;
        rd(3'd1, v); chk("write zero bit0 R9", v, 16'h0002);

        // R9: capture lands on the same edge as a write of 0
        clr_m = 0;
        set_ctrl(1'b1);
        @(negedge clk) cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = '0;
        @(negedge clk);
        wr_en = 1'b0;
        m_cap(); e_of = 0;
        settle();
        rd(3'd1, v); chk("set wins R9", v, 16'h0001);
        drive_cap(0);
        check_all("after set wins R9");

        // R10: unmapped addresses read zero
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); chk($sformatf("unmapped %0d R10", a), v, '0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule